// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with Alarm

This peripheral keeps a 64-bit count of nanoseconds. The count moves forward by a fixed nanosecond step on every clock cycle. Software on a 32-bit register bus reads and writes the count one 32-bit half at a time. A read of the lower half freezes a copy of the upper half, so a following read of the upper half belongs to the same instant even if a carry has passed between the two reads.

A single 64-bit alarm target is compared against the count. Software loads the upper half of the target first. Writing the lower half then starts the comparison. If the target is already at or behind the count at that moment, the interrupt becomes pending at once and nothing is armed. Otherwise the alarm stays armed until the count reaches the target. The interrupt output is a level: it is high while an event is pending and the enable bit is set. Separate write-only registers cancel an armed alarm and acknowledge a pending event.

The bus is a one-cycle handshake. The block samples an access on the clock edge where `bus_valid` is high, and read data appears on the registered `bus_rdata` output after that same edge.

Top module: `ns_rtc`

## Requirements
- R1: After synchronous reset the count equals the RESET_TIME parameter, and the alarm target, the armed flag, the pending flag, the enable bit and `irq` are all zero.
- R2: With no write to a time register, the count grows by STEP_NS on every clock edge, wrapping modulo 2^64.
- R3: A read of offset 0x00 returns the lower 32 bits of the count as it stood at that access edge, and it copies the upper 32 bits into a holding register. A read of offset 0x04 returns the holding register, not the live upper half.
- R4: A write to offset 0x00 replaces bits [31:0] of the count, and a write to 0x04 replaces bits [63:32]. On the next edge the count holds exactly the merged value and then advances by STEP_NS per cycle.
- R5: A write to 0x0C stores target bits [63:32] and never arms the alarm. A write to 0x08 stores target bits [31:0] and evaluates the alarm. Offsets 0x08 and 0x0C read back the stored halves.
- R6: When the alarm is evaluated, the target is compared with the count value loaded on that edge. If the target is less than or equal to that value, the pending flag is set and the alarm stays unarmed.
- R7: An armed alarm disarms and sets the pending flag on the first edge whose newly loaded count is greater than or equal to the target.
- R8: `irq` is high exactly when the pending flag and the enable bit are both set, from the cycle after the edge that changes either one. A write to 0x10 keeps only bit 0 of the data, and 0x10 reads back that bit in bit 0.
- R9: A write to 0x14 with any data disarms the alarm and leaves the pending flag unchanged. If it coincides with the firing edge, the alarm does not fire. Offset 0x18 reads 1 while armed and 0 otherwise.
- R10: A write to 0x1C with any data clears the pending flag. If the alarm fires on the same edge, the flag stays set.
- R11: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x18 (unaligned ones included) return zero, and writes to offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x1C change no state. `bus_rdata` is zero in any cycle after an edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one nanosecond step of STEP_NS per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, sampled on the rising edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid after the access edge |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
Two functions can land on the same clock edge: the alarm firing on its own, and a software write that either acknowledges the interrupt or cancels the alarm. The bench reads the count, sets the alarm target three steps ahead, and places the acknowledge or cancel write exactly on the edge where the count reaches the target. It then judges the outcome at `irq` and at the status register. With an acknowledge, the new event must survive. With a cancel, the alarm must never fire.

// File: rtl/ns_rtc_pkg.sv
package ns_rtc_pkg;

    localparam int TIME_W = 64;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFF_TIME_LO  = 6'h00,
        OFF_TIME_HI  = 6'h04,
        OFF_ALM_LO   = 6'h08,
        OFF_ALM_HI   = 6'h0C,
        OFF_IRQ_EN   = 6'h10,
        OFF_ALM_CLR  = 6'h14,
        OFF_ALM_STAT = 6'h18,
        OFF_IRQ_ACK  = 6'h1C
    } reg_off_e;

    typedef struct packed {
        logic time_lo_wr;
        logic time_hi_wr;
        logic alm_lo_wr;
        logic alm_hi_wr;
        logic en_wr;
        logic alm_clr;
        logic irq_ack;
        logic time_lo_rd;
        logic any_rd;
    } bus_cmd_t;

    // Overwrite one 32-bit half of a 64-bit word.
    function automatic logic [TIME_W-1:0] put_half(
        input logic [TIME_W-1:0] base,
        input logic              upper,
        input logic [DATA_W-1:0] d
    );
        logic [TIME_W-1:0] r;
        r = base;
        if (upper) r[TIME_W-1:DATA_W] = d;
        else       r[DATA_W-1:0]      = d;
        return r;
    endfunction

endpackage

// File: rtl/ns_rtc_decode.sv
module ns_rtc_decode
    import ns_rtc_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_cmd_t          cmd
);
    logic wr, rd;

    always_comb begin
        wr = bus_valid && bus_write;
        rd = bus_valid && !bus_write;
        cmd.time_lo_wr = wr && (bus_addr == OFF_TIME_LO);
        cmd.time_hi_wr = wr && (bus_addr == OFF_TIME_HI);
        cmd.alm_lo_wr  = wr && (bus_addr == OFF_ALM_LO);
        cmd.alm_hi_wr  = wr && (bus_addr == OFF_ALM_HI);
        cmd.en_wr      = wr && (bus_addr == OFF_IRQ_EN);
        cmd.alm_clr    = wr && (bus_addr == OFF_ALM_CLR);
        cmd.irq_ack    = wr && (bus_addr == OFF_IRQ_ACK);
        cmd.time_lo_rd = rd && (bus_addr == OFF_TIME_LO);
        cmd.any_rd     = rd;
    end
endmodule

// File: rtl/ns_rtc_timebase.sv
module ns_rtc_timebase
    import ns_rtc_pkg::*;
#(
    parameter logic [TIME_W-1:0] RESET_TIME = '0,
    parameter int unsigned       STEP_NS    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [TIME_W-1:0] time_q,
    output logic [TIME_W-1:0] time_nxt,
    output logic [DATA_W-1:0] hold_q
);
    localparam logic [TIME_W-1:0] STEP = TIME_W'(STEP_NS);

    always_comb begin
        if (cmd.time_lo_wr)      time_nxt = put_half(time_q, 1'b0, wdata);
        else if (cmd.time_hi_wr) time_nxt = put_half(time_q, 1'b1, wdata);
        else                     time_nxt = time_q + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= RESET_TIME;
            hold_q <= '0;
        end else begin
            time_q <= time_nxt;
            if (cmd.time_lo_rd) hold_q <= time_q[TIME_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/ns_rtc_alarm.sv
module ns_rtc_alarm
    import ns_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_nxt,
    output logic [TIME_W-1:0] target_q,
    output logic              armed_q,
    output logic              pend_q,
    output logic              en_q,
    output logic              irq
);
    logic [TIME_W-1:0] target_n;
    logic              fire_now, match, set_pend, armed_n;

    always_comb begin
        target_n = target_q;
        if (cmd.alm_lo_wr) target_n = put_half(target_n, 1'b0, wdata);
        if (cmd.alm_hi_wr) target_n = put_half(target_n, 1'b1, wdata);

        fire_now = cmd.alm_lo_wr && (target_n <= time_nxt);
        match    = armed_q && (time_nxt >= target_q);

        if (cmd.alm_lo_wr) begin
            armed_n  = !fire_now;
            set_pend = fire_now;
        end else if (cmd.alm_clr) begin
            armed_n  = 1'b0;
            set_pend = 1'b0;
        end else begin
            armed_n  = armed_q && !match;
            set_pend = match;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            armed_q  <= 1'b0;
            pend_q   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            target_q <= target_n;
            armed_q  <= armed_n;
            if (set_pend)         pend_q <= 1'b1;
            else if (cmd.irq_ack) pend_q <= 1'b0;
            if (cmd.en_wr)        en_q   <= wdata[0];
        end
    end

    assign irq = pend_q && en_q;
endmodule

// File: rtl/ns_rtc.sv
module ns_rtc
    import ns_rtc_pkg::*;
#(
    parameter logic [63:0] RESET_TIME = 64'd0,
    parameter int unsigned STEP_NS    = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    bus_cmd_t          cmd;
    logic [TIME_W-1:0] time_q, time_nxt, target_q;
    logic [DATA_W-1:0] hold_q;
    logic              alm_armed, alm_pend, irq_en;

    ns_rtc_decode u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cmd       (cmd)
    );

    ns_rtc_timebase #(
        .RESET_TIME (RESET_TIME),
        .STEP_NS    (STEP_NS)
    ) u_time (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (bus_wdata),
        .time_q   (time_q),
        .time_nxt (time_nxt),
        .hold_q   (hold_q)
    );

    ns_rtc_alarm u_alm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (bus_wdata),
        .time_nxt (time_nxt),
        .target_q (target_q),
        .armed_q  (alm_armed),
        .pend_q   (alm_pend),
        .en_q     (irq_en),
        .irq      (irq)
    );

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        case (reg_off_e'(bus_addr))
            OFF_TIME_LO:  rd_mux = time_q[DATA_W-1:0];
            OFF_TIME_HI:  rd_mux = hold_q;
            OFF_ALM_LO:   rd_mux = target_q[DATA_W-1:0];
            OFF_ALM_HI:   rd_mux = target_q[TIME_W-1:DATA_W];
            OFF_IRQ_EN:   rd_mux = {{(DATA_W-1){1'b0}}, irq_en};
            OFF_ALM_STAT: rd_mux = {{(DATA_W-1){1'b0}}, alm_armed};
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)             bus_rdata <= '0;
        else if (cmd.any_rd) bus_rdata <= rd_mux;
        else                 bus_rdata <= '0;
    end
endmodule

// File: rtl/ns_rtc_chk.sv
module ns_rtc_chk #(
    parameter int unsigned STEP_NS = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [5:0]  bus_addr,
    input logic        irq,
    input logic [63:0] time_q,
    input logic        armed,
    input logic        pend,
    input logic        en
);
    logic wr, time_wr, alm_lo_w, alm_hi_w, clr_w, ack_w;
    assign wr       = bus_valid && bus_write;
    assign time_wr  = wr && (bus_addr == 6'h00 || bus_addr == 6'h04);
    assign alm_lo_w = wr && (bus_addr == 6'h08);
    assign alm_hi_w = wr && (bus_addr == 6'h0C);
    assign clr_w    = wr && (bus_addr == 6'h14);
    assign ack_w    = wr && (bus_addr == 6'h1C);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !time_wr |=> time_q == $past(time_q) + 64'(STEP_NS));

    // R5
    high_no_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (alm_hi_w && !armed) |=> !armed);

    // R6
    low_eval_chk: assert property (@(posedge clk) disable iff (rst)
        alm_lo_w |=> (armed || pend));

    // R7
    fire_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !clr_w && !alm_lo_w) |=> (armed || pend));

    // R9
    cancel_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> !armed);

    // R9
    cancel_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_w && pend) |=> pend);

    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_w && !armed) |=> !pend);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq);
endmodule

bind ns_rtc ns_rtc_chk #(.STEP_NS(STEP_NS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .irq       (irq),
    .time_q    (time_q),
    .armed     (alm_armed),
    .pend      (alm_pend),
    .en        (irq_en)
);

// File: tb/tb_ns_rtc.sv
`timescale 1ns/1ps
module tb_ns_rtc;
    localparam logic [63:0] RST_T = 64'h0000_0002_FFFF_FF00;
    localparam int unsigned STEP  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_valid = 1'b0, b_write = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    ns_rtc #(.RESET_TIME(RST_T), .STEP_NS(STEP)) dut (
        .clk(clk), .rst(rst), .bus_valid(b_valid), .bus_write(b_write),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata), .irq(irq)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0, started = 0;

    // Reference model built from the requirements.
    logic [63:0] m_cnt, m_tgt, nx, tn;
    logic [31:0] m_hold, m_rd;
    logic        m_arm, m_pend, m_en, setp;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = RST_T; m_tgt = '0; m_hold = '0; m_rd = '0;
            m_arm = 0; m_pend = 0; m_en = 0;
        end else begin
            nx = m_cnt + 64'(STEP);
            m_rd = '0;
            if (b_valid && b_write && b_addr == 6'h00) nx = {m_cnt[63:32], b_wdata};
            if (b_valid && b_write && b_addr == 6'h04) nx = {b_wdata, m_cnt[31:0]};
            if (b_valid && !b_write) begin
                case (b_addr)
                    6'h00: begin m_rd = m_cnt[31:0]; m_hold = m_cnt[63:32]; end
                    6'h04: m_rd = m_hold;
                    6'h08: m_rd = m_tgt[31:0];
                    6'h0C: m_rd = m_tgt[63:32];
                    6'h10: m_rd = {31'b0, m_en};
                    6'h18: m_rd = {31'b0, m_arm};
                    default: m_rd = '0;
                endcase
            end
            tn = m_tgt;
            setp = 0;
            if (b_valid && b_write && b_addr == 6'h08) begin
                tn[31:0] = b_wdata;
                setp = (tn <= nx);
                m_arm = !setp;
            end else if (b_valid && b_write && b_addr == 6'h14) begin
                m_arm = 0;
            end else if (m_arm && nx >= m_tgt) begin
                m_arm = 0; setp = 1;
            end
            if (b_valid && b_write && b_addr == 6'h0C) tn[63:32] = b_wdata;
            m_tgt = tn;
            if (setp) m_pend = 1;
            else if (b_valid && b_write && b_addr == 6'h1C) m_pend = 0;
            if (b_valid && b_write && b_addr == 6'h10) m_en = b_wdata[0];
            m_cnt = nx;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && started)
            chk(irq === (m_pend & m_en), "R8 irq level", 64'(irq), 64'(m_pend & m_en));
    end

    // Tasks start and end at a falling edge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        b_valid = 1; b_write = 1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_valid = 0; b_write = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        string t;
        b_valid = 1; b_write = 0; b_addr = a;
        @(negedge clk);
        b_valid = 0;
        v = rdata;
        if (a == 6'h00 || a == 6'h04)      t = "R3 time read";
        else if (a == 6'h08 || a == 6'h0C) t = "R5 target readback";
        else if (a == 6'h10)               t = "R8 enable readback";
        else if (a == 6'h18)               t = "R9 armed status";
        else                               t = "R11 unmapped read";
        chk(v === m_rd, t, 64'(v), 64'(m_rd));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [63:0] c;
        int unsigned seed;
        bit fired;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 0;
        started = 1;

        // R1 reset state
        chk(irq === 1'b0, "R1 irq after reset", 64'(irq), 0);
        rd(6'h10, v); chk(v == 0, "R1 enable zero", 64'(v), 0);
        rd(6'h18, v); chk(v == 0, "R1 armed zero", 64'(v), 0);
        rd(6'h08, v); chk(v == 0, "R1 target low zero", 64'(v), 0);
        rd(6'h0C, v); chk(v == 0, "R1 target high zero", 64'(v), 0);
        rd(6'h00, v); rd(6'h04, v2);
        chk(v2 == RST_T[63:32], "R1 count seeded upper", 64'(v2), 64'(RST_T[63:32]));

        // R2 step
        rd(6'h00, v); idle(4); rd(6'h00, v2);
        chk(v2 - v == 5 * STEP, "R2 step per cycle", 64'(v2 - v), 64'(5 * STEP));

        // R3 / R4 coherent split across a carry
        wr(6'h04, 32'd5); wr(6'h00, 32'hFFFF_FFF0);
        rd(6'h00, v); chk(v == 32'hFFFF_FFF0, "R4 low write exact", 64'(v), 64'hFFFF_FFF0);
        idle(5);
        rd(6'h04, v); chk(v == 32'd5, "R3 snapshot not live", 64'(v), 5);
        rd(6'h00, v); rd(6'h04, v2);
        chk(v2 == 32'd6, "R3 carry seen after new low read", 64'(v2), 6);

        // R5 / R6 / R8 / R10
        wr(6'h04, 32'h10); wr(6'h00, 32'h1000);
        wr(6'h0C, 32'h10);
        rd(6'h18, v); chk(v == 0, "R5 high write does not arm", 64'(v), 0);
        wr(6'h08, 32'h500);
        rd(6'h18, v); chk(v == 0, "R6 past target not armed", 64'(v), 0);
        chk(irq == 0, "R8 gated by enable", 64'(irq), 0);
        wr(6'h10, 32'hFFFF_FFFF);
        chk(irq == 1, "R6 past target pending", 64'(irq), 1);
        wr(6'h10, 32'hFFFF_FFFE);
        chk(irq == 0, "R8 only bit 0 kept", 64'(irq), 0);
        wr(6'h10, 32'h1);
        wr(6'h1C, 32'hABCD);
        chk(irq == 0, "R10 ack clears", 64'(irq), 0);

        // R7 future target
        c = m_cnt;
        wr(6'h08, c[31:0] + 32'(STEP * 20));
        rd(6'h18, v); chk(v == 1, "R7 armed", 64'(v), 1);
        fired = 0;
        for (int i = 0; i < 40 && !fired; i++) begin
            if (irq) fired = 1; else idle(1);
        end
        chk(fired, "R7 alarm fired", 64'(fired), 1);
        rd(6'h18, v); chk(v == 0, "R7 disarmed after fire", 64'(v), 0);
        rd(6'h00, v);
        chk(v >= c[31:0] + 32'(STEP * 20), "R7 count reached target", 64'(v), 64'(c[31:0] + 32'(STEP * 20)));

        // R9 cancel keeps pending
        c = m_cnt;
        wr(6'h08, c[31:0] + 32'd100000);
        wr(6'h14, 32'h0);
        rd(6'h18, v); chk(v == 0, "R9 cancel disarms", 64'(v), 0);
        chk(irq == 1, "R9 pending untouched", 64'(irq), 1);
        wr(6'h1C, 0);

        // R10 collision: ack on the firing edge
        c = m_cnt;
        wr(6'h08, c[31:0] + 32'(3 * STEP)); idle(1); wr(6'h1C, 0);
        chk(irq == 1, "R10 fire wins over ack", 64'(irq), 1);
        wr(6'h1C, 0);

        // R9 collision: cancel on the firing edge
        c = m_cnt;
        wr(6'h08, c[31:0] + 32'(3 * STEP)); idle(1); wr(6'h14, 0);
        chk(irq == 0, "R9 cancel beats fire", 64'(irq), 0);
        idle(3);
        chk(irq == 0, "R9 stays quiet", 64'(irq), 0);

        // R11 unmapped offsets
        wr(6'h20, 32'h1); wr(6'h3C, 32'hFFFF_FFFF); wr(6'h11, 32'h0); wr(6'h09, 32'h0);
        rd(6'h10, v); chk(v == 1, "R11 stray writes ignored", 64'(v), 1);
        rd(6'h14, v); rd(6'h1C, v); rd(6'h20, v); rd(6'h02, v);
        chk(rdata == 0, "R11 idle rdata zero", 64'(rdata), 0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0: wr(6'h00, $urandom);
                1: wr(6'h04, $urandom % 4);
                2: wr(6'h08, m_cnt[31:0] + ($urandom % 400) - 32'd60);
                3: wr(6'h0C, m_cnt[63:32] + ($urandom % 2));
                4: wr(6'h10, $urandom);
                5: wr(6'h14, $urandom);
                6: wr(6'h1C, $urandom);
                default: rd(6'(($urandom % 16) * 4), v);
            endcase
            idle(int'($urandom % 3));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule